// File: doc/BRIEF.md
# Scan Sequence Repeat Controller

This block sits beside a scan shift engine and decides what happens each time a shift finishes. In single-vector operation a finished shift simply ends the run. In sequencer operation the block keeps two budgets: a vector budget, which counts how many vectors of the sequence are still to be shifted, and a retry budget, which counts how many times the whole sequence may be run again after a failing comparison.

After every accepted shift-complete event the block issues exactly one command pulse, one clock later. The command tells the surrounding control either to run the sequence again from its first step, to fetch the next vector, or to go back to idle. When a run ends, the block leaves a pass or fail status that stays set until the host starts the next run. A host start pulse reloads both budgets from their configuration inputs.

Top module: `scan_repeat_ctrl`

## Requirements
- R1: A `start` pulse loads the retry budget from `retry_cfg` and the vector budget from `vec_cfg` (a value of 0 counts as 1), raises `busy`, clears `done_pass` and `fail_sticky`, and issues no command in the following cycle.
- R2: With `seq_mode` = 0 (single-vector), an accepted shift-complete gives `cmd_idle` one cycle later and `busy` drops; `fail_sticky` is set if `cmp_en` and `cmp_fail` were both 1, otherwise `done_pass` is set.
- R3: With `seq_mode` = 1, a shift-complete with `cmp_en` = 1 and `cmp_fail` = 1 while the retry budget is non-zero gives `cmd_restart`, lowers the retry budget by one and reloads the vector budget from `vec_cfg`.
- R4: With `seq_mode` = 1, a shift-complete with `cmp_en` = 1 and `cmp_fail` = 0 while more than one vector remains gives `cmd_next_vec` and lowers the vector budget by one.
- R5: With `seq_mode` = 1 and `cmp_en` = 0, the value of `cmp_fail` has no effect: the event is handled as a passing vector.
- R6: With `seq_mode` = 1, a passing or non-compared shift-complete while one vector remains gives `cmd_idle`, drops `busy` and sets `done_pass`.
- R7: With `seq_mode` = 1, a failing shift-complete while the retry budget is zero gives `cmd_idle`, drops `busy` and sets `fail_sticky`, which stays set until the next `start`.
- R8: Each command is a one-cycle pulse, at most one of the three is high in any cycle, and a command appears only in the cycle after an accepted shift-complete.
- R9: A shift-complete is accepted only while `busy` is 1 and `start` is 0; otherwise it produces no command and leaves the budgets and status unchanged, and `start` wins when both arrive together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Host start pulse; reloads budgets and begins a run |
| seq_mode | input | 1 | 1 = sequencer operation, 0 = single vector |
| retry_cfg | input | CW | Number of whole-sequence retries allowed after failures |
| vec_cfg | input | CW | Number of vectors in the sequence (0 treated as 1) |
| shift_done | input | 1 | One-cycle pulse when a scan shift has finished |
| cmp_en | input | 1 | Comparison (or masked comparison) was enabled for the shift |
| cmp_fail | input | 1 | Comparison result of the shift, 1 = mismatch |
| cmd_restart | output | 1 | Pulse: run the sequence again from its first step |
| cmd_next_vec | output | 1 | Pulse: go on to fetch the next vector |
| cmd_idle | output | 1 | Pulse: the run is over, return to idle |
| busy | output | 1 | A run is in progress |
| done_pass | output | 1 | Last run ended with a pass (held until next start) |
| fail_sticky | output | 1 | Last run ended after retries ran out (held until next start) |

## Verification
A wrong budget value never shows directly; it shows as a command of the wrong kind at the end of a run: a `cmd_next_vec` where `cmd_idle` was due, or a `cmd_restart` where the retries should have run out. The bench therefore sweeps every small vector and retry setting against every four-event pass/fail pattern, with and without compare, so an off-by-one budget is seen at the first event where the run should have ended or restarted. Wrong state in the status path is caught at the end of each run and again after a stray shift-complete in idle, one cycle after the event that caused it.

// File: rtl/scan_rpt_pkg.sv
package scan_rpt_pkg;

  typedef enum logic [2:0] {
    DEC_NONE     = 3'd0,
    DEC_RESTART  = 3'd1,
    DEC_NEXT     = 3'd2,
    DEC_END_PASS = 3'd3,
    DEC_END_FAIL = 3'd4
  } rpt_dec_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } rpt_state_e;

  // A decision that terminates the run
  function automatic logic dec_is_end(rpt_dec_e d);
    return (d == DEC_END_PASS) || (d == DEC_END_FAIL);
  endfunction

endpackage

// File: rtl/rpt_budget_cnt.sv
module rpt_budget_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic [W-1:0] cnt,
  output logic         is_zero,
  output logic         is_one
);

  localparam logic [W-1:0] ONE = W'(1);

  function automatic logic [W-1:0] step_down(logic [W-1:0] v);
    return v - ONE;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (load)   cnt <= load_val;
    else if (dec)    cnt <= step_down(cnt);
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == ONE);

  // a budget is never decremented through zero
  AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !load) |-> !is_zero) else $error("budget wrap"); // R3

endmodule

// File: rtl/rpt_decide.sv
module rpt_decide
  import scan_rpt_pkg::*;
(
  input  logic     fire,
  input  logic     seq_mode,
  input  logic     cmp_en,
  input  logic     cmp_fail,
  input  logic     retry_zero,
  input  logic     vec_last,
  output rpt_dec_e dec
);

  logic fail_hit;
  assign fail_hit = cmp_en && cmp_fail;

  always_comb begin
    dec = DEC_NONE;
    if (fire) begin
      if (!seq_mode) begin
        dec = fail_hit ? DEC_END_FAIL : DEC_END_PASS;
      end else if (fail_hit) begin
        dec = retry_zero ? DEC_END_FAIL : DEC_RESTART;
      end else begin
        dec = vec_last ? DEC_END_PASS : DEC_NEXT;
      end
    end
  end

endmodule

// File: rtl/scan_repeat_ctrl.sv
module scan_repeat_ctrl
  import scan_rpt_pkg::*;
#(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          seq_mode,
  input  logic [CW-1:0] retry_cfg,
  input  logic [CW-1:0] vec_cfg,
  input  logic          shift_done,
  input  logic          cmp_en,
  input  logic          cmp_fail,
  output logic          cmd_restart,
  output logic          cmd_next_vec,
  output logic          cmd_idle,
  output logic          busy,
  output logic          done_pass,
  output logic          fail_sticky
);

  // zero vectors would be meaningless: run at least one
  function automatic logic [CW-1:0] vec_budget(logic [CW-1:0] cfg);
    return (cfg == '0) ? CW'(1) : cfg;
  endfunction

  rpt_state_e    state;
  rpt_dec_e      dec;
  logic          fire;
  logic          retry_zero, retry_one_unused;
  logic          vec_zero_unused, vec_last;
  logic [CW-1:0] retry_cnt, vec_cnt;
  logic          retry_load, retry_dec, vec_load, vec_dec;

  assign busy = (state == ST_RUN);
  assign fire = busy && shift_done && !start;

  rpt_decide u_decide (
    .fire       (fire),
    .seq_mode   (seq_mode),
    .cmp_en     (cmp_en),
    .cmp_fail   (cmp_fail),
    .retry_zero (retry_zero),
    .vec_last   (vec_last),
    .dec        (dec)
  );

  assign retry_load = start;
  assign retry_dec  = (dec == DEC_RESTART);
  assign vec_load   = start || (dec == DEC_RESTART);
  assign vec_dec    = (dec == DEC_NEXT);

  rpt_budget_cnt #(.W(CW)) u_retry (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (retry_load),
    .load_val (retry_cfg),
    .dec      (retry_dec),
    .cnt      (retry_cnt),
    .is_zero  (retry_zero),
    .is_one   (retry_one_unused)
  );

  rpt_budget_cnt #(.W(CW)) u_vec (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (vec_load),
    .load_val (vec_budget(vec_cfg)),
    .dec      (vec_dec),
    .cnt      (vec_cnt),
    .is_zero  (vec_zero_unused),
    .is_one   (vec_last)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      cmd_restart  <= 1'b0;
      cmd_next_vec <= 1'b0;
      cmd_idle     <= 1'b0;
      done_pass    <= 1'b0;
      fail_sticky  <= 1'b0;
    end else begin
      cmd_restart  <= (dec == DEC_RESTART);
      cmd_next_vec <= (dec == DEC_NEXT);
      cmd_idle     <= dec_is_end(dec);
      if (start) begin
        state       <= ST_RUN;
        done_pass   <= 1'b0;
        fail_sticky <= 1'b0;
      end else if (dec_is_end(dec)) begin
        state       <= ST_IDLE;
        done_pass   <= (dec == DEC_END_PASS);
        fail_sticky <= (dec == DEC_END_FAIL);
      end
    end
  end

  AST_START_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done_pass && !fail_sticky && !cmd_idle && !cmd_restart && !cmd_next_vec
      && retry_cnt == $past(retry_cfg)) else $error("start"); // R1
  AST_ONE_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_restart, cmd_next_vec, cmd_idle})) else $error("cmd"); // R8
  AST_CMD_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_restart || cmd_next_vec || cmd_idle) |-> $past(busy && shift_done && !start))
    else $error("cause"); // R8
  AST_IDLE_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !cmd_idle && !cmd_restart && !cmd_next_vec
      && $stable(done_pass) && $stable(fail_sticky)) else $error("idle"); // R9
  AST_END_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_idle |-> !busy && (done_pass != fail_sticky)) else $error("end"); // R6
  AST_FAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fail_sticky && !start) |=> fail_sticky) else $error("sticky"); // R7
  AST_RESTART_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_restart |-> vec_cnt == vec_budget($past(vec_cfg))) else $error("reload"); // R3

endmodule

// File: tb/sim_scan_repeat_ctrl.sv
module sim_scan_repeat_ctrl;

  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, seq_mode = 1'b0, shift_done = 1'b0, cmp_en = 1'b0, cmp_fail = 1'b0;
  logic [CW-1:0] retry_cfg = '0, vec_cfg = '0;
  logic cmd_restart, cmd_next_vec, cmd_idle, busy, done_pass, fail_sticky;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  scan_repeat_ctrl #(.CW(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .seq_mode(seq_mode),
    .retry_cfg(retry_cfg), .vec_cfg(vec_cfg), .shift_done(shift_done),
    .cmp_en(cmp_en), .cmp_fail(cmp_fail), .cmd_restart(cmd_restart),
    .cmd_next_vec(cmd_next_vec), .cmd_idle(cmd_idle), .busy(busy),
    .done_pass(done_pass), .fail_sticky(fail_sticky)
  );

  // command code seen at the ports: 4=restart 2=next 1=idle
  function automatic int cmd_code();
    return {29'd0, cmd_restart, cmd_next_vec, cmd_idle};
  endfunction

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_start(int s, int v, bit sm);
    @(negedge clk);
    start = 1; retry_cfg = CW'(s); vec_cfg = CW'(v); seq_mode = sm;
    @(negedge clk);
    start = 0;
  endtask

  // one shift-complete pulse; returns the command seen one cycle later
  task automatic do_shift(bit en, bit fl, output int code);
    @(negedge clk);
    shift_done = 1; cmp_en = en; cmp_fail = fl;
    @(negedge clk);
    shift_done = 0; cmp_en = 0; cmp_fail = 0;
    code = cmd_code();
  endtask

  task automatic run_seq(int s, int v, int pat, bit en);
    int vrem, srem, code, exp;
    bit ended, exp_pass;
    vrem = (v == 0) ? 1 : v;
    srem = s;
    ended = 0; exp_pass = 0;
    do_start(s, v, 1'b1);
    chk("R1 busy after start", busy, 1);
    chk("R1 status cleared", {done_pass, fail_sticky}, 0);
    for (int k = 0; k < 80 && !ended; k++) begin
      bit raw_fail, eff_fail;
      raw_fail = pat[k % 4];
      eff_fail = en && raw_fail;
      if (eff_fail) begin
        if (srem == 0) begin exp = 1; ended = 1; exp_pass = 0; end
        else begin exp = 4; srem--; vrem = (v == 0) ? 1 : v; end
      end else begin
        if (vrem <= 1) begin exp = 1; ended = 1; exp_pass = 1; end
        else begin exp = 2; vrem--; end
      end
      do_shift(en, raw_fail, code);
      if (!en)            chk("R5 compare off ignores fail", code, exp);
      else if (exp == 4)  chk("R3 fail restarts", code, exp);
      else if (exp == 2)  chk("R4 pass next vector", code, exp);
      else if (exp_pass)  chk("R6 vectors done", code, exp);
      else                chk("R7 retries out", code, exp);
    end
    chk("R6 R7 busy dropped", busy, 0);
    chk("R6 pass status", done_pass, exp_pass ? 1 : 0);
    chk("R7 fail status", fail_sticky, exp_pass ? 0 : 1);
    // stray event in idle
    begin
      int c2;
      do_shift(1'b1, 1'b1, c2);
      chk("R9 idle event ignored", c2, 0);
      chk("R9 status kept", {done_pass, fail_sticky}, exp_pass ? 2 : 1);
      chk("R8 pulse one cycle", cmd_code(), 0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int code;
    repeat (3) @(negedge clk);
    chk("R1 reset busy", busy, 0);
    chk("R8 reset cmds", cmd_code(), 0);
    chk("R1 reset status", {done_pass, fail_sticky}, 0);
    rst_n = 1;
    @(negedge clk);

    // idle event before any start
    do_shift(1'b0, 1'b0, code);
    chk("R9 idle before start", code, 0);
    chk("R9 still idle", busy, 0);

    // single-vector mode, all compare combinations
    for (int m = 0; m < 4; m++) begin
      bit e, f;
      e = m[1]; f = m[0];
      do_start(2, 3, 1'b0);
      do_shift(e, f, code);
      chk("R2 single ends", code, 1);
      chk("R2 busy low", busy, 0);
      chk("R2 status", {done_pass, fail_sticky}, (e && f) ? 1 : 2);
    end

    // start together with shift-complete: start wins, budgets reloaded
    do_start(0, 2, 1'b1);
    do_shift(1'b1, 1'b0, code);
    chk("R4 first of two", code, 2);
    @(negedge clk);
    start = 1; shift_done = 1; cmp_en = 1; cmp_fail = 0;
    @(negedge clk);
    start = 0; shift_done = 0; cmp_en = 0;
    chk("R9 start wins", cmd_code(), 0);
    do_shift(1'b1, 1'b0, code);
    chk("R9 budget reloaded", code, 2);
    do_shift(1'b1, 1'b0, code);
    chk("R6 ends after reload", code, 1);

    // sweep of sequencer configurations
    for (int en = 0; en < 2; en++)
      for (int v = 0; v < 5; v++)
        for (int s = 0; s < 4; s++)
          for (int p = 0; p < 16; p++)
            run_seq(s, v, p, en[0]);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule